// File: doc/BRIEF.md
# Key-Enabled Watchdog Timer

This block is a supervisory timer for a small processor core. Firmware controls it through two write-only registers on a simple write bus. One is a key register: a single reserved value (0x55) keeps the timer halted, and any other value lets it run. The other is a restart register: any write to it brings the count back to zero. The key register returns to the reserved value on every reset, so the timer is always halted when the core starts.

When it is enabled, the counter advances by one on each clock where the machine-cycle strobe is high. The strobe normally pulses once every four core clocks. When the counter wraps past its top value, the block raises a reset request for exactly one clock, and the counter continues from zero. Firmware that keeps working writes the restart register often enough that the counter never wraps. The counter width is a parameter, 24 bits by default, and a smaller value lets a test reach overflow quickly.

Top module: `key_watchdog`

## Requirements
- R1: After a synchronous reset, the key register holds 0x55, the counter is zero, `wd_reset_req` is low, and the timer stays halted until firmware enables it.
- R2: While the key register holds 0x55, the counter does not advance, whatever the strobe does.
- R3: A write of any value other than 0x55, including 0x00, to bus address 0xAE enables counting. The new key value applies from the clock after the write.
- R4: Once enabled, the counter overflows after 2^CNT_W advances from zero. It wraps to zero at that edge, and `wd_reset_req` goes high in the cycle that follows.
- R5: The counter advances only on clocks where `mc_tick` is high.
- R6: A write of any data to bus address 0xA6 reloads the counter with zero, whether or not the timer is enabled. If the timer is enabled, counting resumes on the next strobe.
- R7: Writing 0x55 to the key register while the timer runs freezes the counter at its current value without clearing it. Enabling the timer again continues from that value.
- R8: A write to any address other than 0xAE or 0xA6, and any bus activity while `bus_we` is low, changes neither the key nor the counter.
- R9: When a restart write and a strobe arrive in the same clock, the restart wins. The counter becomes zero and no reset request follows, even if the counter was at its top value.
- R10: `wd_reset_req` is high for exactly one clock per overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous system reset, active high |
| mc_tick | input | 1 | Machine-cycle strobe that lets the counter advance |
| bus_addr | input | ADDR_W (8) | Register address of a bus write |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| wd_reset_req | output | 1 | One-clock reset request raised on overflow |

## Verification
The bench tracks a count from the requirements and predicts the exact clock of each reset request. An off-by-one in the overflow limit, or a counter that ignores the strobe, would therefore move the pulse and be caught. A freeze that also clears the count would make the next pulse arrive late. A restart that loses to a simultaneous strobe at the top value would produce an extra pulse. Writes of the reserved value to neighbouring addresses would halt a timer that should keep running, and a restart that is ignored while the timer is halted would make the following pulse come early.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [7:0] KWD_HOLD_KEY = 8'h55;

  typedef struct packed {
    logic key_wr;
    logic restart;
  } kwd_cmd_t;
endpackage

// File: rtl/kwd_decode.sv
module kwd_decode
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hAE,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 8'hA6
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output kwd_cmd_t          cmd
);
  function automatic logic hit(input logic w, input logic [ADDR_W-1:0] a,
                               input logic [ADDR_W-1:0] target);
    return w && (a == target);
  endfunction

  always_comb begin
    cmd.key_wr  = hit(we, addr, KEY_ADDR);
    cmd.restart = hit(we, addr, RESTART_ADDR);
  end
endmodule

// File: rtl/kwd_keyreg.sv
module kwd_keyreg
  import kwd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] HOLD_KEY = KWD_HOLD_KEY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              run
);
  logic [DATA_W-1:0] key_q;

  always_ff @(posedge clk) begin
    if (rst)         key_q <= HOLD_KEY;
    else if (key_wr) key_q <= wdata;
  end

  assign run = (key_q != HOLD_KEY);

  assert_key_load_R3: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> (key_q == $past(wdata)));
  assert_key_untouched_R8: assert property (@(posedge clk) disable iff (rst)
    !key_wr |=> $stable(key_q));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             wrap_pulse
);
  localparam int SUM_W = CNT_W + 1;

  function automatic logic [SUM_W-1:0] bump(input logic [CNT_W-1:0] c);
    return {1'b0, c} + SUM_W'(1);
  endfunction

  logic [SUM_W-1:0] sum;
  logic             advance;
  logic             wrap_now;

  assign sum      = bump(count);
  assign advance  = run && tick;
  assign wrap_now = advance && !restart && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= wrap_now;
      if (restart)      count <= '0;
      else if (advance) count <= sum[CNT_W-1:0];
    end
  end

  assert_halted_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(count));
  assert_no_tick_no_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(count));
  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> (count == '0));
  assert_restart_no_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> !wrap_pulse);
  assert_pulse_after_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |-> (count == '0));
  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |=> !wrap_pulse);
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import kwd_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hAE,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] HOLD_KEY = KWD_HOLD_KEY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic              wd_reset_req
);
  kwd_cmd_t         cmd;
  logic             run;
  logic [CNT_W-1:0] count;

  kwd_decode #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .RESTART_ADDR(RESTART_ADDR))
    u_decode (.we(bus_we), .addr(bus_addr), .cmd(cmd));

  kwd_keyreg #(.DATA_W(DATA_W), .HOLD_KEY(HOLD_KEY))
    u_key (.clk(clk), .rst(rst), .key_wr(cmd.key_wr), .wdata(bus_wdata), .run(run));

  kwd_counter #(.CNT_W(CNT_W))
    u_cnt (.clk(clk), .rst(rst), .tick(mc_tick), .run(run), .restart(cmd.restart),
           .count(count), .wrap_pulse(wd_reset_req));

  assert_restart_ignores_key_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr != RESTART_ADDR && !(run && mc_tick)) |=> $stable(count));
endmodule

// File: tb/key_watchdog_test.sv
module key_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, we = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  wire req;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_watchdog #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .mc_tick(tick), .bus_addr(addr),
    .bus_wdata(wdata), .bus_we(we), .wd_reset_req(req));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int exp_q[$];
  int n_chk = 0, n_fail = 0, unexp = 0;
  logic mon_on = 1'b0;
  int m_cnt = 0;
  logic [7:0] m_key = 8'h55;

  // Monitor: pops predicted pulse cycles and compares with the output
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        n_chk++;
        void'(exp_q.pop_front());
        if (req !== 1'b1) begin
          n_fail++;
          $display("FAIL R4: request at cycle %0d was %b, expected 1", cyc, req);
        end
      end else if (req !== 1'b0) begin
        unexp++;
      end
    end
  end

  // Driver: one clock of stimulus, with the expected count kept per requirements
  task automatic step(input logic t, input logic w, input logic [7:0] a, input logic [7:0] d);
    tick = t; we = w; addr = a; wdata = d;
    if (w && a == 8'hA6) m_cnt = 0;
    else if (t && m_key != 8'h55) begin
      if (m_cnt == MAXC) begin m_cnt = 0; exp_q.push_back(cyc + 1); end
      else m_cnt++;
    end
    if (w && a == 8'hAE) m_key = d;
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
  endtask

  task automatic strobes(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 8'h00, 8'h00);
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 8'h00, 8'h00);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic quiet(input string tag);
    step(1'b0, 1'b0, 8'h00, 8'h00);
    step(1'b0, 1'b0, 8'h00, 8'h00);
    n_chk++;
    if (unexp != 0 || exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: stray pulses %0d, missed pulses %0d, expected 0 and 0",
               tag, unexp, exp_q.size());
    end
    unexp = 0;
    exp_q.delete();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_key = 8'h55; exp_q.delete(); unexp = 0;
    n_chk++;
    if (req !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: request after reset was %b, expected 0", req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    mon_on = 1'b1;
    // R1, R2: halted after reset
    strobes(40, 0);
    quiet("R1_R2 halted after reset");
    // R3, R4, R5: enable with 0xAA, strobe every 4th clock
    wr(8'hAE, 8'hAA);
    strobes(16, 3);
    quiet("R3_R4_R5 first overflow");
    // R4, R10: wrap to zero and overflow again
    strobes(16, 1);
    quiet("R4_R10 second overflow");
    // R6: restart mid-count
    strobes(10, 0);
    wr(8'hA6, 8'h3C);
    strobes(10, 0);
    quiet("R6 restart delays overflow");
    strobes(6, 0);
    quiet("R6 overflow after restart");
    // R7: freeze without clear, resume with 0x00
    strobes(5, 0);
    wr(8'hAE, 8'h55);
    strobes(30, 0);
    quiet("R7 frozen");
    wr(8'hAE, 8'h00);
    strobes(11, 0);
    quiet("R7_R3 resume from held value");
    // R8: other addresses and unstrobed bus ignored
    strobes(4, 0);
    wr(8'hAF, 8'h55);
    wr(8'hA7, 8'h00);
    wr(8'h00, 8'h55);
    step(1'b0, 1'b0, 8'hAE, 8'h55);
    step(1'b0, 1'b0, 8'hA6, 8'h00);
    strobes(12, 0);
    quiet("R8 stray writes ignored");
    // R9: restart and strobe together at the top value
    strobes(15, 0);
    step(1'b1, 1'b1, 8'hA6, 8'h00);
    strobes(15, 0);
    quiet("R9 restart beats strobe");
    strobes(1, 0);
    quiet("R9 full period after tie");
    // R6: restart while halted still clears
    strobes(8, 0);
    wr(8'hAE, 8'h55);
    wr(8'hA6, 8'h00);
    wr(8'hAE, 8'h01);
    strobes(15, 0);
    quiet("R6 halted restart clears");
    strobes(1, 0);
    quiet("R6 overflow after halted restart");
    // R1: reset mid-run returns to halted
    strobes(5, 0);
    mon_on = 1'b0;
    do_reset();
    mon_on = 1'b1;
    strobes(40, 0);
    quiet("R1 halted after second reset");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule